// File: doc/BRIEF.md
# Fuse shadow cache loader

This block copies a fixed set of rows out of a one-time-programmable fuse array into a bank of read-only shadow words. Once loaded, the rest of the chip reads fuse-derived settings from the shadows and never touches the slow array. The array is reached through a simple row-read port. The block raises a row-read enable together with a 6-bit row number, and the array returns that 32-bit row one cycle later. A fuse bit is located at row × 32 + column, with 32 columns in a row.

A load starts by itself when reset is released. Software can start another load by writing the cache-load register with bit 0 set. The sequencer steps through 42 rows in ascending order, one read per cycle. Each returned row goes into its shadow word, and the user-control row is masked on the way in. At the end the sequencer latches three test-bit check results and sets a cache-done flag in the status word.

The security-control row is also driven out on a dedicated port, so that downstream lock and disable logic can use it directly. The status word and all shadows can be read on a register read port, which has one cycle of latency.

Top module: `fuse_shadow_loader`

## Requirements
- R1: Reset starts a load with no software action. While it runs, the cache-done flag (status bit 4) reads 0. Once it completes, the flag reads 1.
- R2: A write to word address 0x30 with bit 0 of the data set starts a load, and cache-done reads 0 from the next cycle on. A write with bit 0 clear, or a write to any other address, changes no state.
- R3: The array is read one row per cycle and data returns one cycle after the request. For a requested load, cache-done is set on the 43rd rising edge after the edge that accepts the request.
- R4: A load request that arrives while a load is running is ignored. The running load keeps its timing and is not restarted.
- R5: A load reads exactly rows 3–6, 8–17, 20–23 and 40–63. Each row is read once, in ascending order, and no other row is ever requested.
- R6: Read addresses 1–3 return rows 3–5 (device identifier). Address 4 returns row 6 (IP disables). Addresses 5–12 return user rows 8–15.
- R7: Address 13 returns row 16 with bits 17–31 forced to zero.
- R8: Addresses 14–18 return rows 17, 20, 21, 22 and 23 (ROM-reserved, PUF hash, PUF misc, security control, secondary key ID). Row 22 is copied bit for bit, and the same word drives the sec_ctrl port.
- R9: Addresses 19–30 return rows 40–51 (public key 0). Addresses 31–42 return rows 52–63 (public key 1).
- R10: Address 0 is the status word. Bits 2:0 hold the three test-bit results latched at the end of the last load, bit 4 holds cache-done, and every other bit is 0. Addresses 43–63 read as 0.
- R11: Read data appears on the clock edge after the read address is presented, and reset clears it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_wr | input | 1 | Register write strobe |
| load_addr | input | 6 | Register write word address |
| load_wdata | input | 32 | Register write data |
| tbit_ok | input | 3 | Test-bit check results, latched at load completion |
| row_rd_en | output | 1 | Fuse row read request |
| row_rd_addr | output | 6 | Fuse row number |
| row_rd_data | input | 32 | Fuse row data, valid one cycle after the request |
| bus_rd_addr | input | 6 | Register read word address |
| bus_rd_data | output | 32 | Register read data, one cycle latency |
| sec_ctrl | output | 32 | Security-control shadow |

## Verification
Every fuse row carries a different value with high bits set, so two kinds of fault show up in the shadow read-back: a mapping off by one row, and a missing mask on row 16. The exact cycle in which cache-done rises is checked both after a normal request and after a second request is injected in the middle of a load. A design that restarted on that second request would still show the flag clear at the expected edge. Writes with bit 0 clear and writes to other addresses are followed by a status read and a shadow read, with the array contents and test-bit inputs changed beforehand. A load that ran when it should not would therefore show new data or a different status. A bench-side log of row requests catches any skipped row, repeated row, out-of-order row or forbidden row.

// File: rtl/fuse_shadow_loader.sv
`timescale 1ns/1ps
module fuse_shadow_loader #(
  parameter int DataW = 32,
  parameter int AddrW = 6,
  parameter int RowAW = 6,
  parameter logic [AddrW-1:0] LOAD_ADDR = 6'h30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_wr,
  input  logic [AddrW-1:0] load_addr,
  input  logic [DataW-1:0] load_wdata,
  input  logic [2:0]       tbit_ok,
  output logic             row_rd_en,
  output logic [RowAW-1:0] row_rd_addr,
  input  logic [DataW-1:0] row_rd_data,
  input  logic [AddrW-1:0] bus_rd_addr,
  output logic [DataW-1:0] bus_rd_data,
  output logic [DataW-1:0] sec_ctrl
);
  localparam int NROWS       = 42;
  localparam int CntW        = $clog2(NROWS + 1);
  localparam int UCTL_STEP   = 12;
  localparam int SECCTL_STEP = 16;
  localparam int UCTL_BITS   = 17;
  localparam int DONE_BIT    = 4;
  localparam logic [DataW-1:0] UCTL_MASK = {{(DataW-UCTL_BITS){1'b0}}, {UCTL_BITS{1'b1}}};

  logic             busy, done, cap_vld;
  logic [CntW-1:0]  cnt, cap_idx;
  logic [2:0]       tbits;
  logic [DataW-1:0] shadow [NROWS];
  logic [DataW-1:0] rd_next;

  function automatic logic [RowAW-1:0] step_row(input logic [CntW-1:0] k);
    int r;
    int kk;
    kk = int'(k);
    if (kk < 4)       r = kk + 3;
    else if (kk < 14) r = kk + 4;
    else if (kk < 18) r = kk + 6;
    else              r = kk + 22;
    return RowAW'(r);
  endfunction

  wire issuing  = busy && (cnt < CntW'(NROWS));
  wire req      = load_wr && (load_addr == LOAD_ADDR) && load_wdata[0];
  wire last_cap = cap_vld && (cap_idx == CntW'(NROWS - 1));

  assign row_rd_en   = issuing;
  assign row_rd_addr = step_row(cnt);
  assign sec_ctrl    = shadow[SECCTL_STEP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      cnt     <= '0;
      cap_vld <= 1'b0;
      cap_idx <= '0;
      tbits   <= '0;
    end else begin
      cap_vld <= issuing;
      cap_idx <= cnt;
      if (issuing) cnt <= cnt + 1'b1;
      if (last_cap) begin
        busy  <= 1'b0;
        done  <= 1'b1;
        tbits <= tbit_ok;
      end
      if (req && !busy) begin
        busy <= 1'b1;
        done <= 1'b0;
        cnt  <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NROWS; i++) shadow[i] <= '0;
    end else if (cap_vld) begin
      shadow[cap_idx] <= (cap_idx == CntW'(UCTL_STEP)) ? (row_rd_data & UCTL_MASK) : row_rd_data;
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_rd_addr == '0) begin
      rd_next[2:0]     = tbits;
      rd_next[DONE_BIT] = done;
    end else if (bus_rd_addr <= AddrW'(NROWS)) begin
      rd_next = shadow[bus_rd_addr - 1'b1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rd_data <= '0;
    else        bus_rd_data <= rd_next;
  end
endmodule

// File: rtl/fuse_shadow_loader_chk.sv
`timescale 1ns/1ps
module fuse_shadow_loader_chk #(
  parameter int AddrW = 6,
  parameter int RowAW = 6,
  parameter int CntW  = 6,
  parameter int NROWS = 42,
  parameter logic [AddrW-1:0] LOAD_ADDR = 6'h30
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             load_wr,
  input logic [AddrW-1:0] load_addr,
  input logic             load_bit,
  input logic             row_rd_en,
  input logic [RowAW-1:0] row_rd_addr,
  input logic [CntW-1:0]  cnt,
  input logic [31:0]      sec_ctrl
);
  wire row_legal = (row_rd_addr >= 6'd3  && row_rd_addr <= 6'd6)  ||
                   (row_rd_addr >= 6'd8  && row_rd_addr <= 6'd17) ||
                   (row_rd_addr >= 6'd20 && row_rd_addr <= 6'd23) ||
                   (row_rd_addr >= 6'd40);

  // R5
  row_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_rd_en |-> row_legal);

  // R5
  row_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_rd_en |=> (!row_rd_en || row_rd_addr > $past(row_rd_addr)));

  // R3
  read_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_rd_en |-> busy);

  // R1
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done}));

  // R2
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_wr && load_addr == LOAD_ADDR && load_bit && !busy) |=> (busy && !done));

  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0 && cnt < CntW'(NROWS)) |=> (cnt == CntW'($past(cnt) + 1'b1)));

  // R8
  secctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(sec_ctrl));
endmodule

bind fuse_shadow_loader fuse_shadow_loader_chk #(
  .AddrW(AddrW), .RowAW(RowAW), .CntW(CntW), .NROWS(NROWS), .LOAD_ADDR(LOAD_ADDR)
) chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .load_wr(load_wr),
  .load_addr(load_addr), .load_bit(load_wdata[0]), .row_rd_en(row_rd_en),
  .row_rd_addr(row_rd_addr), .cnt(cnt), .sec_ctrl(sec_ctrl)
);

// File: tb/fuse_shadow_loader_test.sv
`timescale 1ns/1ps
module fuse_shadow_loader_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        load_wr = 0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_wdata = '0;
  logic [2:0]  tbit_ok = 3'b101;
  logic        row_rd_en;
  logic [5:0]  row_rd_addr;
  logic [31:0] row_rd_data = '0;
  logic [5:0]  bus_rd_addr = '0;
  logic [31:0] bus_rd_data;
  logic [31:0] sec_ctrl;

  localparam logic [5:0] LOADA = 6'h30;

  fuse_shadow_loader uut (
    .clk(clk), .rst_n(rst_n), .load_wr(load_wr), .load_addr(load_addr),
    .load_wdata(load_wdata), .tbit_ok(tbit_ok), .row_rd_en(row_rd_en),
    .row_rd_addr(row_rd_addr), .row_rd_data(row_rd_data),
    .bus_rd_addr(bus_rd_addr), .bus_rd_data(bus_rd_data), .sec_ctrl(sec_ctrl)
  );

  always #4 clk = ~clk;

  logic [31:0] mem [64];
  int nreads, nbad, last_row;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  logic [5:0]  q_addr [$];
  logic [31:0] q_exp  [$];
  string       q_tag  [$];

  function automatic logic [31:0] pat(input int row, input logic [7:0] seed);
    logic [7:0] r8;
    r8 = 8'(row);
    return {seed, r8, ~seed, 8'hC0 | r8};
  endfunction

  function automatic bit legal_row(input int r);
    return (r >= 3 && r <= 6) || (r >= 8 && r <= 17) || (r >= 20 && r <= 23) || (r >= 40 && r <= 63);
  endfunction

  function automatic logic [31:0] exp_word(input int a, input logic [7:0] seed);
    if (a >= 1 && a <= 3)   return pat(a + 2, seed);
    if (a == 4)             return pat(6, seed);
    if (a >= 5 && a <= 12)  return pat(a + 3, seed);
    if (a == 13)            return pat(16, seed) & 32'h0001_FFFF;
    if (a == 14)            return pat(17, seed);
    if (a >= 15 && a <= 18) return pat(a + 5, seed);
    if (a >= 19 && a <= 42) return pat(a + 21, seed);
    return 32'h0;
  endfunction

  function automatic string tag_of(input int a);
    if (a <= 4)  return "R6";
    if (a <= 12) return "R6";
    if (a == 13) return "R7";
    if (a <= 18) return "R8";
    if (a <= 42) return "R9";
    return "R10";
  endfunction

  always @(posedge clk) begin
    if (rst_n && row_rd_en) begin
      int r;
      r = int'(row_rd_addr);
      row_rd_data <= mem[r];
      nreads++;
      if (!legal_row(r) || r <= last_row) nbad++;
      last_row = r;
    end
  end

  always begin
    @(posedge clk);
    #2;
    if (q_exp.size() > 0) begin
      logic [5:0]  a;
      logic [31:0] e;
      string       t;
      a = q_addr.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      nchk++;
      if (bus_rd_data !== e) begin
        nfail++;
        $display("FAIL %s addr %0d: actual %h expected %h", t, a, bus_rd_data, e);
      end
    end
  end

  task automatic fill(input logic [7:0] seed);
    for (int i = 0; i < 64; i++) mem[i] = pat(i, seed);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    bus_rd_addr = a;
    q_addr.push_back(a);
    q_exp.push_back(e);
    q_tag.push_back(t);
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    load_wr = 1; load_addr = a; load_wdata = d;
    @(negedge clk);
    load_wr = 0; load_addr = '0; load_wdata = '0;
  endtask

  task automatic check(input string t, input logic [31:0] act, input logic [31:0] e);
    nchk++;
    if (act !== e) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  task automatic read_all(input logic [7:0] seed);
    for (int a = 1; a < 64; a++) rd(6'(a), exp_word(a, seed), tag_of(a));
  endtask

  initial begin
    fill(8'h3C);
    nreads = 0; nbad = 0; last_row = -1;
    repeat (3) @(negedge clk);
    rd(6'd0, 32'h0, "R11 reset");
    rst_n = 1;
    rd(6'd0, 32'h0, "R1 loading");
    repeat (60) @(negedge clk);
    rd(6'd0, 32'h15, "R1 done");
    check("R5 row count", 32'(nreads), 32'd42);
    check("R5 row order", 32'(nbad), 32'd0);
    check("R8 sec_ctrl port", sec_ctrl, pat(22, 8'h3C));
    read_all(8'h3C);

    tbit_ok = 3'b010;
    fill(8'hA7);
    nreads = 0; last_row = -1;
    rd(6'd0, 32'h15, "R10 tbits latched");
    wr(LOADA, 32'h2);
    wr(6'h31, 32'h1);
    repeat (50) @(negedge clk);
    rd(6'd0, 32'h15, "R2 bit0 clear or wrong address");
    rd(6'd1, pat(3, 8'h3C), "R2 shadow unchanged");
    check("R2 no row reads", 32'(nreads), 32'd0);

    wr(LOADA, 32'h1);
    rd(6'd0, 32'h05, "R2 done cleared");
    repeat (3) @(negedge clk);
    wr(LOADA, 32'h1);
    repeat (37) @(negedge clk);
    rd(6'd0, 32'h05, "R4 R3 done not yet set");
    rd(6'd0, 32'h12, "R3 done edge");
    check("R5 row count reload", 32'(nreads), 32'd42);
    check("R5 row order reload", 32'(nbad), 32'd0);
    check("R8 sec_ctrl reload", sec_ctrl, pat(22, 8'hA7));
    read_all(8'hA7);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule